// File: doc/BRIEF.md
# Multi-Device Serial Host Controller

This block is the host-side register front end of a serial peripheral bus that serves several on-board devices. Software programs a 16-bit control word that picks the target device, enables the port, holds chip select across bytes and enables an interrupt. Software then pushes bytes through an 8-bit data path. Each accepted byte goes to the selected device, along with the chip-select hold flag. The reply byte from that device can be read back, and a single-cycle interrupt pulse marks each completed byte when interrupts are on.

The byte-level serialisation is abstracted. Every attached device is a stub that takes a byte in one cycle and offers a reply derived from it. The block therefore covers these parts:
- the control masking and the busy indication;
- the routing of write and read data;
- the gating by the enable bit;
- the sticky diagnostic flags;
- the interrupt.

Write data arrives on a valid/ready stream. A byte is taken on any rising edge where `dat_valid` and `dat_ready` are both high. After a byte that reaches a device, the port is busy for one cycle and `dat_ready` is low. The producer must then hold `dat_valid` and `dat_wdata` until ready returns. Control writes and the read paths are plain and never stall.

Top module: `spi_hub`

## Requirements
- R1: After reset the control readback is 0, `irq`, `mode16_warn`, `unmapped_err` and every `dev_cs` bit are 0, and `dat_ready` is 1.
- R2: A control write stores only the bits set in mask 0xCF03. In the control readback, bit 7 reports busy and all other bits outside that mask read 0.
- R3: Busy (readback bit 7) is 1 in the cycle after a byte reaches a device and 0 otherwise. The value of bit 7 in a control write has no effect on it.
- R4: Control bits 9:8 select the device: value 0 selects device 0 and value 1 selects device 1. With the port enabled, the data readback is the selected device's reply to its last byte. Device 0 replies with the byte unchanged, and device 1 replies with the byte XOR 0x3C.
- R5: While control bit 15 (enable) is 0, accepted data bytes change no device state, raise no interrupt and set no busy, and the data readback is 0.
- R6: When a byte reaches a device, that device's `dev_cs` output takes the value of control bit 11 (hold). Other devices' chip selects are unchanged.
- R7: When control bit 14 is 1 and a byte reaches a device, `irq` is 1 for exactly the following cycle. Otherwise `irq` stays 0.
- R8: A control write with bit 10 (16-bit mode, unsupported) set sets `mode16_warn`, which stays 1 until reset.
- R9: With the port enabled and device select 2 or 3, an accepted byte is dropped: no device changes, and there is no busy and no interrupt. `unmapped_err` is set and stays set until reset. The data readback is 0 while such a select is programmed.
- R10: `wide_rdata` carries the control readback in bits 15:0, the data readback in bits 23:16, and 0 in bits 31:24. Only bits 7:0 of `dat_wdata` are used.
- R11: `dat_ready` is 0 exactly while busy is 1. A byte is accepted only on an edge where `dat_valid` and `dat_ready` are both 1, and a byte that gets through uses the control value from before a same-edge control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write value |
| dat_valid | input | 1 | Write byte valid |
| dat_ready | output | 1 | Controller can take a byte |
| dat_wdata | input | 16 | Write data, low byte used |
| ctl_rdata | output | 16 | Control readback with busy in bit 7 |
| dat_rdata | output | 8 | Reply byte of the selected device, gated |
| wide_rdata | output | 32 | Combined control and data readback |
| irq | output | 1 | One-cycle completion interrupt |
| mode16_warn | output | 1 | Sticky unsupported 16-bit mode flag |
| unmapped_err | output | 1 | Sticky write-to-unmapped-device flag |
| dev_cs | output | NUM_DEV | Chip select held per device |

## Verification
Every result of an accepted byte is due one clock edge after acceptance. This covers the reply byte, chip select, busy, the interrupt, the dropped-byte error and the low ready. A control write shows in the readback and the warning flag after that same one edge. The bench drives inputs at the falling edge and advances its own model at the rising edge. It compares all outputs 1 ns after that edge, so each check lands in the cycle the result is due. Directed cases cover a control write in the busy cycle, a byte offered during back-pressure, and a control change on the same edge as an accepted byte.

// File: rtl/spi_hub_pkg.sv
package spi_hub_pkg;
  localparam int CTL_W = 16;
  localparam logic [CTL_W-1:0] CTL_STORE_MASK = 16'hCF03;
  localparam int BIT_BUSY   = 7;
  localparam int BIT_MODE16 = 10;
  localparam int BIT_HOLD   = 11;
  localparam int BIT_IE     = 14;
  localparam int BIT_EN     = 15;
  localparam int SEL_LO     = 8;

  // Reply transform of stub device k: XOR with k*0x3C (low byte)
  function automatic logic [7:0] dev_key(input int k);
    return 8'(k * 60);
  endfunction
endpackage

// File: rtl/spi_hub_ctrl.sv
module spi_hub_ctrl
  import spi_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             warn_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      warn_q <= 1'b0;
    end else if (we) begin
      ctl_q <= wdata & CTL_STORE_MASK;
      if (wdata[BIT_MODE16]) warn_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_hub_route.sv
module spi_hub_route #(
  parameter int NUM_DEV = 2,
  parameter int SEL_W   = 2,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ie,
  input  logic [SEL_W-1:0]   sel,
  input  logic               dat_valid,
  output logic               dat_ready,
  output logic [NUM_DEV-1:0] dev_we,
  input  logic [DW-1:0]      dev_rbyte [NUM_DEV],
  output logic [DW-1:0]      rbyte,
  output logic               busy_q,
  output logic               irq_q,
  output logic               err_q
);
  logic accept, mapped, hit;

  assign mapped    = (32'(sel) < NUM_DEV);
  assign dat_ready = !busy_q;
  assign accept    = dat_valid && dat_ready;
  assign hit       = accept && en && mapped;

  generate
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_we
      assign dev_we[k] = hit && (32'(sel) == k);
    end
  endgenerate

  always_comb begin
    rbyte = '0;
    for (int k = 0; k < NUM_DEV; k++)
      if (en && 32'(sel) == k) rbyte = dev_rbyte[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= hit;
      irq_q  <= hit && ie;
      if (accept && en && !mapped) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_hub_echo_dev.sv
module spi_hub_echo_dev #(
  parameter int         DW  = 8,
  parameter logic [7:0] KEY = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          hold,
  input  logic [DW-1:0] wbyte,
  output logic [DW-1:0] rbyte,
  output logic          cs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbyte <= '0;
      cs    <= 1'b0;
    end else if (we) begin
      rbyte <= wbyte ^ DW'(KEY);
      cs    <= hold;
    end
  end
endmodule

// File: rtl/spi_hub.sv
module spi_hub
  import spi_hub_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [15:0]        ctl_wdata,
  input  logic               dat_valid,
  output logic               dat_ready,
  input  logic [15:0]        dat_wdata,
  output logic [15:0]        ctl_rdata,
  output logic [7:0]         dat_rdata,
  output logic [31:0]        wide_rdata,
  output logic               irq,
  output logic               mode16_warn,
  output logic               unmapped_err,
  output logic [NUM_DEV-1:0] dev_cs
);
  localparam int DW = 8;

  logic [CTL_W-1:0]   ctl_q;
  logic [NUM_DEV-1:0] dev_we;
  logic [DW-1:0]      dev_rbyte [NUM_DEV];
  logic               busy;

  spi_hub_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl_q(ctl_q), .warn_q(mode16_warn)
  );

  spi_hub_route #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W), .DW(DW)) u_route (
    .clk(clk), .rst_n(rst_n),
    .en(ctl_q[BIT_EN]), .ie(ctl_q[BIT_IE]), .sel(ctl_q[SEL_LO +: SEL_W]),
    .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dev_we(dev_we), .dev_rbyte(dev_rbyte), .rbyte(dat_rdata),
    .busy_q(busy), .irq_q(irq), .err_q(unmapped_err)
  );

  generate
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
      spi_hub_echo_dev #(.DW(DW), .KEY(dev_key(k))) u_dev (
        .clk(clk), .rst_n(rst_n), .we(dev_we[k]), .hold(ctl_q[BIT_HOLD]),
        .wbyte(dat_wdata[DW-1:0]), .rbyte(dev_rbyte[k]), .cs(dev_cs[k])
      );
    end
  endgenerate

  always_comb begin
    ctl_rdata           = ctl_q;
    ctl_rdata[BIT_BUSY] = busy;
  end

  assign wide_rdata = {8'h00, dat_rdata, ctl_rdata};
endmodule

// File: rtl/spi_hub_chk.sv
module spi_hub_chk #(
  parameter int NUM_DEV = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_we,
  input logic               dat_valid,
  input logic               dat_ready,
  input logic [15:0]        ctl_rdata,
  input logic [7:0]         dat_rdata,
  input logic               irq,
  input logic               mode16_warn,
  input logic               unmapped_err,
  input logic [NUM_DEV-1:0] dev_cs
);
  // R2: nothing outside the store mask and the busy bit reads back
  p_ctl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~16'hCF83) == 16'h0000);

  // R11: no acceptance while busy
  p_busy_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7] |-> !dat_ready);

  // R5: disabled port reads zero
  p_off_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[15] |-> dat_rdata == 8'h00);

  // R7: interrupt follows an accepted, enabled byte with interrupts on
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(dat_valid && dat_ready && ctl_rdata[15] && ctl_rdata[14]));

  // R7: pulse lasts one cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: chip selects move only after an accepted byte
  p_cs_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_cs) |-> $past(dat_valid && dat_ready));

  // R8: warning is sticky
  p_warn_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode16_warn |=> mode16_warn);

  // R9: error is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_err |=> unmapped_err);
endmodule

bind spi_hub spi_hub_chk #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .dat_valid(dat_valid),
  .dat_ready(dat_ready), .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata),
  .irq(irq), .mode16_warn(mode16_warn), .unmapped_err(unmapped_err),
  .dev_cs(dev_cs)
);

// File: tb/spi_hub_tb_top.sv
`timescale 1ns/1ps
module spi_hub_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic dat_valid = 1'b0;
  logic [15:0] dat_wdata = '0;
  logic dat_ready, irq, mode16_warn, unmapped_err;
  logic [15:0] ctl_rdata;
  logic [7:0]  dat_rdata;
  logic [31:0] wide_rdata;
  logic [1:0]  dev_cs;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_hub dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_wdata(dat_wdata),
    .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata), .wide_rdata(wide_rdata),
    .irq(irq), .mode16_warn(mode16_warn), .unmapped_err(unmapped_err),
    .dev_cs(dev_cs)
  );

  // model state
  logic [15:0] m_ctl;
  logic m_busy, m_irq, m_warn, m_err;
  logic [1:0] m_cs;
  logic [7:0] m_byte [2];

  function automatic logic [7:0] reply(input int d, input logic [7:0] b);
    return (d == 1) ? (b ^ 8'h3C) : b;  // R4
  endfunction

  function automatic logic [7:0] exp_dat();
    if (!m_ctl[15]) return 8'h00;
    if (m_ctl[9:8] > 2'd1) return 8'h00;
    return m_byte[m_ctl[9:8]];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [15:0] ec;
    string dtag;
    ec = m_ctl | (16'(m_busy) << 7);
    dtag = !m_ctl[15] ? "R5" : (m_ctl[9:8] > 2'd1 ? "R9" : "R4");
    chk("R2 control readback", 32'(ctl_rdata), 32'(ec));
    chk("R3 busy bit", 32'(ctl_rdata[7]), 32'(m_busy));
    chk(dtag, 32'(dat_rdata), 32'(exp_dat()));
    chk("R7 irq", 32'(irq), 32'(m_irq));
    chk("R11 ready", 32'(dat_ready), 32'(!m_busy));
    chk("R6 chip select", 32'(dev_cs), 32'(m_cs));
    chk("R8 warn", 32'(mode16_warn), 32'(m_warn));
    chk("R9 err", 32'(unmapped_err), 32'(m_err));
    chk("R10 wide", wide_rdata, {8'h00, exp_dat(), ec});
  endtask

  // one cycle: drive at falling edge, model at rising edge, check after
  task automatic step(input logic cw, input logic [15:0] cv,
                      input logic dv, input logic [15:0] dvv);
    logic acc;
    @(negedge clk);
    ctl_we = cw; ctl_wdata = cv; dat_valid = dv; dat_wdata = dvv;
    @(posedge clk);
    acc = dv && !m_busy;
    m_busy = 1'b0; m_irq = 1'b0;
    if (acc && m_ctl[15]) begin
      if (m_ctl[9:8] <= 2'd1) begin
        m_byte[m_ctl[9:8]] = reply(int'(m_ctl[9:8]), dvv[7:0]);
        m_cs[m_ctl[9:8]] = m_ctl[11];
        m_busy = 1'b1;
        m_irq = m_ctl[14];
      end else m_err = 1'b1;
    end
    if (cw) begin
      m_ctl = cv & 16'hCF03;
      if (cv[10]) m_warn = 1'b1;
    end
    #1;
    check_all();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    m_ctl = '0; m_busy = 0; m_irq = 0; m_warn = 0; m_err = 0; m_cs = '0;
    m_byte[0] = '0; m_byte[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 control", 32'(ctl_rdata), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 flags", 32'({mode16_warn, unmapped_err, dev_cs}), 32'h0);
    chk("R1 ready", 32'(dat_ready), 32'h1);

    // R5: disabled port ignores bytes
    step(1, 16'h4900, 0, 0);
    step(0, 0, 1, 16'h00A5);
    step(0, 0, 0, 0);
    // R4 device 0 echo with hold and irq, R7 pulse
    step(1, 16'hC800 | 16'h00FF, 0, 0);
    step(0, 0, 1, 16'hFF5A);
    // R3: control write during busy with bit7 clear; busy keeps its own value
    step(1, 16'hC100, 1, 16'h0011);   // R11 offered while busy, not taken
    step(0, 0, 1, 16'h0011);          // device 1, reply ^3C
    step(1, 16'h8180, 0, 0);          // R3 bit7 written high does not set busy
    // R9 unmapped devices
    step(1, 16'hC200, 0, 0);
    step(0, 0, 1, 16'h0077);
    step(1, 16'hC300, 1, 16'h0078);   // R11 same-edge change uses old control
    // R8 mode16 warning
    step(1, 16'h0400, 0, 0);
    step(1, 16'h0000, 0, 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] cv;
      cv = 16'($urandom);
      if ($urandom_range(0, 9) < 8) cv[15] = 1'b1;
      if ($urandom_range(0, 9) < 7) cv[9] = 1'b0;
      if ($urandom_range(0, 19) != 0) cv[10] = 1'b0;
      step($urandom_range(0, 3) == 0, cv, $urandom_range(0, 2) != 0, 16'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule